// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a single-port synchronous memory with a 36-bit word split into four 9-bit lanes (eight data bits and one parity bit each). Every control input, the address and the write data are captured on the rising clock edge. Read data is then loaded into an output register, so a read address sampled on one edge produces data after the following edge. The same data path serves reads and writes.

Writes can be limited to chosen lanes. A lane-write enable arms the per-lane selects, and a global write overrides them to write the whole word. Three chip-select inputs, two active low and one active high, must all agree before a cycle does anything. An asynchronous output enable gates the data output and a drive-qualifier flag that stands in for a tri-state buffer. The first read after a deselected cycle is never driven, so that banks of these memories can share a bus safely. The burst address sequence is generated outside the block.

The depth is set by an address-width parameter. The default is kept small so that elaboration stays cheap. An address width of 17 gives the full 128K-word part.

Top module: `pipe_sram_bytewr`

## Requirements
- R1: A cycle takes effect only when sel_a_n=0, sel_b=1 and sel_c_n=0. Any other combination writes nothing, even with a write enabled, and leaves dout_drive low after the next edge.
- R2: When dout_drive is high, the data of a read whose address is sampled at edge n appears on dout after edge n+1.
- R3: With lane_wr_en_n=0 and wr_all_n=1, lane i (dout/din bits 9i+8 down to 9i) is written when lane_sel_n[i]=0 and is kept when lane_sel_n[i]=1.
- R4: With wr_all_n=0, all four lanes are written whatever lane_sel_n holds.
- R5: With wr_all_n=1 and lane_wr_en_n=1 the cycle is a read, and lane_sel_n has no effect on memory contents.
- R6: out_en_n acts without a clock edge. While out_en_n=1, dout_drive is low. Whenever dout_drive is low, dout is all zeros.
- R7: A read whose preceding cycle was deselected is not driven during its output cycle. A read that directly follows a selected cycle is driven.
- R8: After reset, dout_drive is low and dout is zero. The first read after reset is treated as following a deselected cycle.
- R9: A selected write cycle does not drive the output in the cycle after its capture edge.
- R10: A read sampled on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low, writes all lanes |
| lane_wr_en_n | input | 1 | Lane-write enable, active low, arms lane_sel_n |
| lane_sel_n | input | 4 | Per-lane write select, active low, bit i selects lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero while not driven |
| dout_drive | output | 1 | High while dout carries valid driven data |

## Verification
The bench builds the block with ADDR_W=6, which gives a 64-word array. At that size every address the vectors touch can be tracked in a small reference model. A table walks lane writes, global writes with all lane selects inactive, writes issued with one select wrong, and reads with stray lane selects. The reads are placed back to back and after idle cycles, which exercises the read latency, the first-read masking and same-address read-after-write. Directed steps then toggle the output enable mid-cycle and apply a reset in the middle of the run.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Active-high select from the three chip-select inputs.
  function automatic logic chip_decode(input logic a_n, input logic b, input logic c_n);
    return (!a_n) && b && (!c_n);
  endfunction

  // Lanes written this cycle: global write wins, otherwise selects count
  // only while the lane-write enable is on.
  function automatic logic [LANES-1:0] lane_mask(input logic wr_all,
                                                 input logic lane_en,
                                                 input logic [LANES-1:0] lane_sel);
    logic [LANES-1:0] m;
    if (wr_all)       m = '1;
    else if (lane_en) m = lane_sel;
    else              m = '0;
    return m;
  endfunction

  // Any write activity turns the cycle into a write cycle.
  function automatic logic is_write(input logic wr_all, input logic lane_en);
    return wr_all || lane_en;
  endfunction
endpackage

// File: rtl/psram_in_reg.sv
module psram_in_reg
  import psram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [WORD_W-1:0] din,
  output logic              sel_q,
  output logic              sel_prev_q,
  output logic              wr_all_q,
  output logic              lane_en_q,
  output logic [LANES-1:0]  lane_sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] din_q
);
  logic sel_now;
  assign sel_now = chip_decode(sel_a_n, sel_b, sel_c_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      sel_prev_q <= 1'b0;
      wr_all_q   <= 1'b0;
      lane_en_q  <= 1'b0;
      lane_sel_q <= '0;
      addr_q     <= '0;
      din_q      <= '0;
    end else begin
      sel_q      <= sel_now;
      sel_prev_q <= sel_q;
      wr_all_q   <= !wr_all_n;
      lane_en_q  <= !lane_wr_en_n;
      lane_sel_q <= ~lane_sel_n;
      addr_q     <= addr;
      din_q      <= din;
    end
  end
endmodule

// File: rtl/psram_lane_bank.sv
module psram_lane_bank
  import psram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic              rd_go,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_go)      lane_q    <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/psram_out_ctl.sv
module psram_out_ctl
  import psram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              after_idle,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dout,
  output logic              dout_drive,
  output logic              out_valid
);
  logic mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      out_valid <= rd_go;
      mask_q    <= rd_go && after_idle;
    end
  end

  assign dout_drive = out_valid && !mask_q && !out_en_n;
  assign dout       = dout_drive ? rdata : '0;

  // R7: a read issued right after a deselected cycle stays undriven
  assert_first_read_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && after_idle) |=> !dout_drive);
endmodule

// File: rtl/pipe_sram_bytewr.sv
module pipe_sram_bytewr
  import psram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [3:0]        lane_sel_n,
  input  logic              out_en_n,
  input  logic [35:0]       din,
  output logic [35:0]       dout,
  output logic              dout_drive
);
  logic              sel_q, sel_prev_q, wr_all_q, lane_en_q;
  logic [LANES-1:0]  lane_sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] din_q, rdata;
  logic              wr_cyc, rd_go, out_valid;
  logic [LANES-1:0]  lane_we;

  psram_in_reg #(.ADDR_W(ADDR_W)) in_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .din(din), .sel_q(sel_q), .sel_prev_q(sel_prev_q), .wr_all_q(wr_all_q),
    .lane_en_q(lane_en_q), .lane_sel_q(lane_sel_q), .addr_q(addr_q), .din_q(din_q)
  );

  assign wr_cyc  = sel_q && is_write(wr_all_q, lane_en_q);
  assign rd_go   = sel_q && !wr_cyc;
  assign lane_we = sel_q ? lane_mask(wr_all_q, lane_en_q, lane_sel_q) : '0;

  psram_lane_bank #(.ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .addr(addr_q), .lane_we(lane_we), .rd_go(rd_go),
    .wdata(din_q), .rdata(rdata)
  );

  psram_out_ctl out_i (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .after_idle(!sel_prev_q),
    .out_en_n(out_en_n), .rdata(rdata), .dout(dout), .dout_drive(dout_drive),
    .out_valid(out_valid)
  );

  // R1: a deselected cycle writes nothing and drives nothing next cycle
  assert_desel_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (lane_we == '0));
  assert_desel_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> !dout_drive);
  // R2: a selected read loads the output register on the next edge
  assert_read_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> out_valid);
  // R3: no lane outside the selected set is written
  assert_lane_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_q && lane_en_q) |-> ((lane_we & ~lane_sel_q) == '0));
  // R4: global write covers every lane
  assert_global_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && wr_all_q) |-> (lane_we == '1));
  // R5: lane selects are inert without an enable
  assert_selects_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_q && !lane_en_q) |-> (lane_we == '0));
  // R9: write cycles leave the output undriven
  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> !dout_drive);
endmodule

// File: tb/pipe_sram_bytewr_tb_top.sv
module pipe_sram_bytewr_tb_top;
  localparam int AW = 6;
  localparam int N  = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          wr_all_n = 1'b1, lane_wr_en_n = 1'b1, out_en_n = 1'b0;
  logic [3:0]    lane_sel_n = 4'hF;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          dout_drive;

  always #10 clk = ~clk;

  pipe_sram_bytewr #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .din(din), .dout(dout),
    .dout_drive(dout_drive)
  );

  // kind: 0 idle, 1 read, 2 lane write, 3 global write, 4 write with sel_b low,
  //       5 read with stray lane selects, 6 write with sel_c_n high
  typedef struct packed {
    logic [2:0]  kind;
    logic [5:0]  addr;
    logic [3:0]  lanes;
    logic [35:0] data;
    logic        drv;
  } vec_t;

  localparam vec_t TBL [N] = '{
    '{3'd2, 6'd3, 4'b0000, 36'h1_2345_6789, 1'b0}, // full lane write (R3)
    '{3'd2, 6'd3, 4'b1010, 36'hA_BCDE_F012, 1'b0}, // lanes 0,2 only (R3)
    '{3'd1, 6'd3, 4'b1111, 36'h0,           1'b1}, // read after write (R10)
    '{3'd3, 6'd5, 4'b1111, 36'h5_5AA5_C33C, 1'b0}, // global override (R4)
    '{3'd1, 6'd5, 4'b1111, 36'h0,           1'b1}, // (R4, R10)
    '{3'd0, 6'd0, 4'b1111, 36'h0,           1'b0},
    '{3'd1, 6'd3, 4'b1111, 36'h0,           1'b0}, // masked first read (R7)
    '{3'd1, 6'd5, 4'b1111, 36'h0,           1'b1}, // (R7)
    '{3'd4, 6'd5, 4'b0000, 36'hF_FFFF_FFFF, 1'b0}, // ignored write (R1)
    '{3'd1, 6'd5, 4'b1111, 36'h0,           1'b0},
    '{3'd1, 6'd5, 4'b1111, 36'h0,           1'b1}, // contents unchanged (R1)
    '{3'd6, 6'd3, 4'b0000, 36'h0_0000_0000, 1'b0}, // ignored write (R1)
    '{3'd3, 6'd9, 4'b1111, 36'h3_1415_9265, 1'b0},
    '{3'd2, 6'd9, 4'b0111, 36'h9_8765_4321, 1'b0}, // lane 3 only (R3)
    '{3'd5, 6'd9, 4'b0000, 36'hE_EEEE_EEEE, 1'b1}, // stray selects (R5)
    '{3'd1, 6'd3, 4'b1111, 36'h0,           1'b1}, // (R1)
    '{3'd2, 6'd3, 4'b1101, 36'h7_7777_7777, 1'b0}, // lane 1 only (R3)
    '{3'd1, 6'd3, 4'b1111, 36'h0,           1'b1}  // (R3, R10)
  };

  logic [35:0] model [64];
  logic [35:0] pend  [N];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] keep_n);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++)
      if (!keep_n[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] kind, input logic drv);
    case (kind)
      3'd1:    return drv ? "R2" : "R7";
      3'd5:    return "R5";
      3'd2, 3'd3: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic ok,
                       input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] kind, input logic [5:0] a,
                       input logic [3:0] lanes, input logic [35:0] d);
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1;
    lane_sel_n = lanes; addr = a; din = d;
    case (kind)
      3'd0: sel_a_n = 1'b1;
      3'd2: begin lane_wr_en_n = 1'b0; model[a] = merge(model[a], d, lanes); end
      3'd3: begin wr_all_n = 1'b0; model[a] = d; end
      3'd4: begin sel_b = 1'b0; wr_all_n = 1'b0; end
      3'd6: begin sel_c_n = 1'b1; wr_all_n = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic check_out(input string tag, input logic exp_drv, input logic [35:0] exp_d);
    logic [35:0] e = exp_drv ? exp_d : 36'h0;
    check(tag, (dout_drive === exp_drv) && (dout === e), {dout_drive, dout}, {exp_drv, e});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check_out("R8", 1'b0, 36'h0);             // reset state
    rst_n = 1'b1;

    for (int j = 0; j < N + 2; j++) begin
      @(negedge clk);
      if (j >= 2) check_out(tag_of(TBL[j-2].kind, TBL[j-2].drv), TBL[j-2].drv, pend[j-2]);
      if (j < N) begin
        pend[j] = model[TBL[j].addr];
        apply(TBL[j].kind, TBL[j].addr, TBL[j].lanes, TBL[j].data);
      end else begin
        apply(3'd0, 6'd0, 4'hF, 36'h0);
      end
    end

    // R6: output enable acts between clock edges
    apply(3'd1, 6'd5, 4'hF, 36'h0);
    @(negedge clk); apply(3'd1, 6'd5, 4'hF, 36'h0);
    @(negedge clk); apply(3'd0, 6'd0, 4'hF, 36'h0);
    @(negedge clk);
    #1 out_en_n = 1'b1;
    #2 check_out("R6", 1'b0, 36'h0);
    out_en_n = 1'b0;
    #2 check_out("R6", 1'b1, model[5]);

    // R8: reset mid-run, first read afterwards is masked
    @(negedge clk);
    apply(3'd1, 6'd5, 4'hF, 36'h0);
    @(posedge clk);
    #3 rst_n = 1'b0;
    #2 check_out("R8", 1'b0, 36'h0);
    @(negedge clk); rst_n = 1'b1; apply(3'd1, 6'd5, 4'hF, 36'h0);
    @(negedge clk); apply(3'd1, 6'd9, 4'hF, 36'h0);
    @(negedge clk); apply(3'd0, 6'd0, 4'hF, 36'h0);
    check_out("R8", 1'b0, 36'h0);
    @(negedge clk);
    check_out("R7", 1'b1, model[9]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule